// File: doc/BRIEF.md
# Speculative Register File with Architectural Backup

This block keeps two copies of the register state for an in-order-issue, out-of-order-completion pipeline. The speculative copy is what the decode stage reads for operands. Each of its entries is either a finished value (valid) or the tag of the instruction that will produce the value (pending). When an instruction is decoded, its destination entry becomes pending under that instruction's tag. When a result completes, it is written into the speculative copy only if its tag is still the one recorded there. This means that only the most recent writer of a register may fill it.

The architectural copy is written only by a commit stream that arrives in program order. When an exception or a resolved misprediction needs the machine state to be restored, the flush request input starts a sequencer. The sequencer copies the architectural copy into the speculative copy one register per cycle. While the copy runs, a busy output stays high. When the copy ends, every speculative entry is valid and equal to its architectural counterpart. The caller waits for the faulting or mispredicted instruction to become oldest before it raises the request.

Top module: `spec_regfile_backup`

## Requirements
- R1: After reset, every speculative entry is valid with value 0, every architectural entry is 0, and busy is low.
- R2: A read port returns valid=1 and the stored value for a valid entry. For a pending entry it returns valid=0, with the producer tag in value bits [TAGW-1:0] and zeros above those bits. The read is combinational on the read address.
- R3: An accepted decode makes the destination entry pending under the decode tag, and this is visible from the cycle after the decode.
- R4: A completion whose destination is pending under exactly the completion tag makes that entry valid with the completion data from the next cycle.
- R5: A completion whose tag differs from the tag recorded for its destination, because a younger writer has decoded since, leaves the entry unchanged.
- R6: When a decode and a matching completion target the same register in the same cycle, the decode wins and the entry becomes pending under the new tag.
- R7: A commit writes only the architectural entry. The speculative entry read back is unchanged by the commit.
- R8: A flush request while idle raises busy in the next cycle and keeps it high for exactly NREG cycles. When busy falls, each speculative entry is valid and holds the architectural value.
- R9: While busy is high, decode, completion, commit and further flush requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| flushReq | input | 1 | Start restoring the speculative copy from the architectural copy |
| busy | output | 1 | High while the copy sequencer runs |
| decValid | input | 1 | Decode of an instruction with a destination |
| decDest | input | AW | Destination register of the decoded instruction |
| decTag | input | TAGW | Producer tag of the decoded instruction |
| cmpValid | input | 1 | Result completion strobe |
| cmpDest | input | AW | Destination register of the completing result |
| cmpTag | input | TAGW | Tag of the completing instruction |
| cmpData | input | DW | Completed result value |
| retValid | input | 1 | In-order commit strobe |
| retDest | input | AW | Register written by the commit |
| retData | input | DW | Value committed |
| rdAddrA | input | AW | Operand read address, port A |
| rdValidA | output | 1 | Port A entry is valid |
| rdValueA | output | DW | Port A value, or producer tag when pending |
| rdAddrB | input | AW | Operand read address, port B |
| rdValidB | output | 1 | Port B entry is valid |
| rdValueB | output | DW | Port B value, or producer tag when pending |

## Verification
Reads are combinational, so each read result is due in the same cycle as its address. Any decode, completion or commit takes effect on the edge that samples it, so its result is due one cycle later. The bench drives on the falling edge and compares a quarter period later, which sets each expected read in the cycle after the update it depends on. Busy is due one cycle after the flush request and must then hold for NREG sampled cycles. The bench counts those cycles and reads the restored registers only after busy has fallen.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  // strobes from the sequencer/gating control to the storage datapath
  typedef struct packed {
    logic copyEn;     // copy one architectural entry into the speculative copy
    logic acceptDec;  // decode update allowed
    logic acceptCmp;  // completion update allowed
    logic acceptRet;  // commit update allowed
  } sfbStrobe_t;
endpackage

// File: rtl/sfb_ctrl.sv
module sfb_ctrl
  import sfb_pkg::*;
#(
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flushReq,
  input  logic          decValid,
  input  logic          cmpValid,
  input  logic          retValid,
  output logic          busy,
  output logic [AW-1:0] copyIdx,
  output sfbStrobe_t    stb
);
  localparam logic [AW-1:0] LAST_IDX = AW'(NREG - 1);

  logic busyQ;
  logic [AW-1:0] idxQ;
  logic startCopy;

  assign startCopy = flushReq && !busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
    end else if (startCopy) begin
      busyQ <= 1'b1;
      idxQ  <= '0;
    end else if (busyQ) begin
      if (idxQ == LAST_IDX) begin
        busyQ <= 1'b0;
        idxQ  <= '0;
      end else begin
        idxQ <= idxQ + 1'b1;
      end
    end
  end

  always_comb begin
    stb.copyEn    = busyQ;
    stb.acceptDec = decValid && !busyQ;
    stb.acceptCmp = cmpValid && !busyQ;
    stb.acceptRet = retValid && !busyQ;
  end

  assign busy    = busyQ;
  assign copyIdx = idxQ;

  // R8: busy only rises in response to a request
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(flushReq));
  // R8: copy begins at register 0
  p_idx_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> copyIdx == '0);
  // R8: sequence ends after the last register
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && copyIdx == LAST_IDX) |=> !busy);
  // R9: no update strobe while copying
  p_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(stb.acceptDec || stb.acceptCmp || stb.acceptRet));
endmodule

// File: rtl/sfb_datapath.sv
module sfb_datapath
  import sfb_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int TAGW = 6,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  sfbStrobe_t      stb,
  input  logic [AW-1:0]   copyIdx,
  input  logic [AW-1:0]   decDest,
  input  logic [TAGW-1:0] decTag,
  input  logic [AW-1:0]   cmpDest,
  input  logic [TAGW-1:0] cmpTag,
  input  logic [DW-1:0]   cmpData,
  input  logic [AW-1:0]   retDest,
  input  logic [DW-1:0]   retData,
  input  logic [AW-1:0]   rdAddrA,
  output logic            rdValidA,
  output logic [DW-1:0]   rdValueA,
  input  logic [AW-1:0]   rdAddrB,
  output logic            rdValidB,
  output logic [DW-1:0]   rdValueB,
  output logic [NREG-1:0] vldVec
);
  // speculative copy: payload is data when valid, tag when pending
  logic [DW-1:0]   specPay [NREG];
  logic [NREG-1:0] specVld;
  logic [DW-1:0]   archData [NREG];

  logic cmpHit;
  logic [DW-1:0] decTagExt;

  assign decTagExt = {{(DW-TAGW){1'b0}}, decTag};
  assign cmpHit = stb.acceptCmp && !specVld[cmpDest]
                  && (specPay[cmpDest][TAGW-1:0] == cmpTag);

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    logic selCopy, selDec, selCmp, selRet;
    assign selCopy = stb.copyEn && (copyIdx == AW'(g));
    assign selDec  = stb.acceptDec && (decDest == AW'(g));
    assign selCmp  = cmpHit && (cmpDest == AW'(g));
    assign selRet  = stb.acceptRet && (retDest == AW'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        specVld[g] <= 1'b1;
        specPay[g] <= '0;
      end else if (selCopy) begin
        specVld[g] <= 1'b1;
        specPay[g] <= archData[g];
      end else if (selDec) begin
        specVld[g] <= 1'b0;           // newest writer takes ownership
        specPay[g] <= decTagExt;
      end else if (selCmp) begin
        specVld[g] <= 1'b1;
        specPay[g] <= cmpData;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) archData[g] <= '0;
      else if (selRet) archData[g] <= retData;
    end
  end

  // pending entries already hold the zero-extended tag in the payload
  assign rdValidA = specVld[rdAddrA];
  assign rdValueA = specPay[rdAddrA];
  assign rdValidB = specVld[rdAddrB];
  assign rdValueB = specPay[rdAddrB];
  assign vldVec   = specVld;

  // R3: a decode leaves its destination pending
  p_dec_pending_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.acceptDec |=> !specVld[$past(decDest)]);
  // R7: a commit lands in the architectural copy
  p_ret_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.acceptRet |=> archData[$past(retDest)] == $past(retData));
  // R8: each copied entry becomes valid
  p_copy_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.copyEn |=> specVld[$past(copyIdx)]);
endmodule

// File: rtl/spec_regfile_backup.sv
module spec_regfile_backup
  import sfb_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int TAGW = 6,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            flushReq,
  output logic            busy,
  input  logic            decValid,
  input  logic [AW-1:0]   decDest,
  input  logic [TAGW-1:0] decTag,
  input  logic            cmpValid,
  input  logic [AW-1:0]   cmpDest,
  input  logic [TAGW-1:0] cmpTag,
  input  logic [DW-1:0]   cmpData,
  input  logic            retValid,
  input  logic [AW-1:0]   retDest,
  input  logic [DW-1:0]   retData,
  input  logic [AW-1:0]   rdAddrA,
  output logic            rdValidA,
  output logic [DW-1:0]   rdValueA,
  input  logic [AW-1:0]   rdAddrB,
  output logic            rdValidB,
  output logic [DW-1:0]   rdValueB
);
  sfbStrobe_t stb;
  logic [AW-1:0] copyIdx;
  logic [NREG-1:0] vldVec;

  sfb_ctrl #(.NREG(NREG)) u_ctrl (
    .clk(clk), .rstN(rstN), .flushReq(flushReq),
    .decValid(decValid), .cmpValid(cmpValid), .retValid(retValid),
    .busy(busy), .copyIdx(copyIdx), .stb(stb)
  );

  sfb_datapath #(.NREG(NREG), .DW(DW), .TAGW(TAGW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .copyIdx(copyIdx),
    .decDest(decDest), .decTag(decTag),
    .cmpDest(cmpDest), .cmpTag(cmpTag), .cmpData(cmpData),
    .retDest(retDest), .retData(retData),
    .rdAddrA(rdAddrA), .rdValidA(rdValidA), .rdValueA(rdValueA),
    .rdAddrB(rdAddrB), .rdValidB(rdValidB), .rdValueB(rdValueB),
    .vldVec(vldVec)
  );

  // R8: all speculative entries are valid once the copy ends
  p_all_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> &vldVec);
endmodule

// File: tb/sim_spec_regfile_backup.sv
module sim_spec_regfile_backup;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int DW = 32;
  localparam int TAGW = 6;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flushReq = 1'b0;
  logic busy;
  logic decValid = 1'b0;
  logic [AW-1:0] decDest = '0;
  logic [TAGW-1:0] decTag = '0;
  logic cmpValid = 1'b0;
  logic [AW-1:0] cmpDest = '0;
  logic [TAGW-1:0] cmpTag = '0;
  logic [DW-1:0] cmpData = '0;
  logic retValid = 1'b0;
  logic [AW-1:0] retDest = '0;
  logic [DW-1:0] retData = '0;
  logic [AW-1:0] rdAddrA = '0;
  logic rdValidA;
  logic [DW-1:0] rdValueA;
  logic [AW-1:0] rdAddrB = '0;
  logic rdValidB;
  logic [DW-1:0] rdValueB;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_regfile_backup #(.NREG(NREG), .DW(DW), .TAGW(TAGW)) u0 (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .busy(busy),
    .decValid(decValid), .decDest(decDest), .decTag(decTag),
    .cmpValid(cmpValid), .cmpDest(cmpDest), .cmpTag(cmpTag), .cmpData(cmpData),
    .retValid(retValid), .retDest(retDest), .retData(retData),
    .rdAddrA(rdAddrA), .rdValidA(rdValidA), .rdValueA(rdValueA),
    .rdAddrB(rdAddrB), .rdValidB(rdValidB), .rdValueB(rdValueB)
  );

  typedef struct {
    bit portB;
    logic expVld;
    logic [DW-1:0] expVal;
    string req;
  } rdItem_t;
  rdItem_t sbq[$];

  // monitor: pops each expected read a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (sbq.size() > 0) begin
        rdItem_t it;
        logic v;
        logic [DW-1:0] d;
        it = sbq.pop_front();
        v = it.portB ? rdValidB : rdValidA;
        d = it.portB ? rdValueB : rdValueA;
        total++;
        if (v !== it.expVld || d !== it.expVal) begin
          bad++;
          $display("FAIL %s: read got vld=%0b val=%h expected vld=%0b val=%h",
                   it.req, v, d, it.expVld, it.expVal);
        end
      end
    end
  end

  task automatic checkBit(string req, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  // driver: at a falling edge, set a read address and queue the expectation
  task automatic expectRead(bit portB, logic [AW-1:0] addr, logic vld,
                            logic [DW-1:0] val, string req);
    rdItem_t it;
    @(negedge clk);
    if (portB) rdAddrB = addr; else rdAddrA = addr;
    it.portB = portB; it.expVld = vld; it.expVal = val; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic idleInputs();
    decValid = 1'b0; cmpValid = 1'b0; retValid = 1'b0; flushReq = 1'b0;
  endtask

  task automatic doDecode(logic [AW-1:0] r, logic [TAGW-1:0] t);
    @(negedge clk); idleInputs();
    decValid = 1'b1; decDest = r; decTag = t;
    @(negedge clk); idleInputs();
  endtask

  task automatic doComplete(logic [AW-1:0] r, logic [TAGW-1:0] t, logic [DW-1:0] d);
    @(negedge clk); idleInputs();
    cmpValid = 1'b1; cmpDest = r; cmpTag = t; cmpData = d;
    @(negedge clk); idleInputs();
  endtask

  task automatic doCommit(logic [AW-1:0] r, logic [DW-1:0] d);
    @(negedge clk); idleInputs();
    retValid = 1'b1; retDest = r; retData = d;
    @(negedge clk); idleInputs();
  endtask

  // R8: request a flush, check busy timing, optionally inject ignored traffic (R9)
  task automatic doFlush(bit inject);
    int cnt;
    @(negedge clk); idleInputs();
    flushReq = 1'b1;
    @(negedge clk); idleInputs();
    #(CLK_PERIOD/4);
    checkBit("R8 busy one cycle after request", busy, 1'b1);
    cnt = 1;
    while (busy) begin
      @(negedge clk); idleInputs();
      if (inject && cnt == 5) begin
        decValid = 1'b1; decDest = 5'd12; decTag = 6'd3;
        retValid = 1'b1; retDest = 5'd12; retData = 32'h0000_0055;
        flushReq = 1'b1;
      end
      if (inject && cnt == 6) begin
        cmpValid = 1'b1; cmpDest = 5'd12; cmpTag = 6'd3; cmpData = 32'h77;
      end
      #(CLK_PERIOD/4);
      if (busy) cnt++;
    end
    total++;
    if (cnt != NREG) begin
      bad++;
      $display("FAIL R8: busy length got %0d expected %0d", cnt, NREG);
    end
    idleInputs();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #(CLK_PERIOD/4);
    checkBit("R1 busy low after reset", busy, 1'b0);
    // R1: reset state of speculative copy
    expectRead(0, 5'd0, 1'b1, 32'h0, "R1 reg0");
    expectRead(0, 5'd31, 1'b1, 32'h0, "R1 reg31");
    expectRead(1, 5'd7, 1'b1, 32'h0, "R1 reg7 port B");

    // R3 / R2: pending entry reads back its tag
    doDecode(5'd3, 6'd5);
    expectRead(0, 5'd3, 1'b0, 32'h5, "R3 R2 pending tag");
    // R4: matching completion fills entry
    doComplete(5'd3, 6'd5, 32'h0000_AAAA);
    expectRead(1, 5'd3, 1'b1, 32'h0000_AAAA, "R4 R2 filled value");

    // R5: stale writer ignored after a younger decode
    doDecode(5'd4, 6'd1);
    doDecode(5'd4, 6'd2);
    doComplete(5'd4, 6'd1, 32'h11);
    expectRead(0, 5'd4, 1'b0, 32'h2, "R5 stale completion ignored");
    doComplete(5'd4, 6'd2, 32'h22);
    expectRead(0, 5'd4, 1'b1, 32'h22, "R4 youngest completion");
    // R5: completion to an already valid entry ignored
    doComplete(5'd4, 6'd2, 32'h99);
    expectRead(0, 5'd4, 1'b1, 32'h22, "R5 completion to valid entry");

    // R6: same-cycle decode and completion, decode wins
    doDecode(5'd6, 6'd8);
    @(negedge clk); idleInputs();
    decValid = 1'b1; decDest = 5'd6; decTag = 6'd9;
    cmpValid = 1'b1; cmpDest = 5'd6; cmpTag = 6'd8; cmpData = 32'h88;
    @(negedge clk); idleInputs();
    expectRead(0, 5'd6, 1'b0, 32'h9, "R6 decode beats completion");

    // R7: commit leaves the speculative copy alone
    doCommit(5'd3, 32'h0000_1234);
    doCommit(5'd10, 32'h0000_BEEF);
    expectRead(0, 5'd3, 1'b1, 32'h0000_AAAA, "R7 spec unchanged by commit");
    expectRead(0, 5'd10, 1'b1, 32'h0, "R7 spec unchanged by commit reg10");

    // R8: restore from architectural copy
    doFlush(1'b0);
    expectRead(0, 5'd3, 1'b1, 32'h0000_1234, "R8 restored reg3");
    expectRead(1, 5'd10, 1'b1, 32'h0000_BEEF, "R8 restored reg10");
    expectRead(0, 5'd6, 1'b1, 32'h0, "R8 pending reg6 restored");
    expectRead(0, 5'd4, 1'b1, 32'h0, "R8 reg4 restored");

    // R9: traffic during copy is ignored
    doFlush(1'b1);
    expectRead(0, 5'd12, 1'b1, 32'h0, "R9 decode/completion ignored while busy");
    @(negedge clk); #(CLK_PERIOD/4);
    checkBit("R9 extra flush request ignored", busy, 1'b0);
    doFlush(1'b0);
    expectRead(0, 5'd12, 1'b1, 32'h0, "R9 commit ignored while busy");
    expectRead(0, 5'd3, 1'b1, 32'h0000_1234, "R8 restore repeatable");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule